// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block is the modem-status part of a serial-port register file. Four active-low modem lines come in from the pins: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a multi-flop synchronizer. The block presents the active-high level of each line in the upper half of an 8-bit status word. The lower half holds sticky change flags, and these clear when the host reads the word. When no modem is attached, the same status bits can be used to read the four pins as general-purpose inputs.

In loopback mode the four levels no longer come from the pins. They are taken straight from the modem-control outputs (request-to-send, data-terminal-ready and two auxiliary outputs), so software can exercise the status path without external wiring. Any pending change flag raises an interrupt request, but only while the modem-status interrupt enable is set.

The block also drives a transmit-hold signal for automatic clear-to-send flow control. The hold value is re-evaluated only while the transmitter reports that it is idle between characters. A character that has already started is therefore always finished before the hold takes effect.

Top module: `modem_status_unit`

## Requirements
- R1: Outside loopback, status bits 7, 6, 5 and 4 equal the inverse of cd_n_pin, ri_n_pin, dsr_n_pin and cts_n_pin. A pin change is visible at the second rising clock edge after it is applied.
- R2: With loopback_en at 1, bit 4 equals mctl_rts, bit 5 equals mctl_dtr, bit 6 equals mctl_out1 and bit 7 equals mctl_out2, in the same cycle. The pins have no effect on the status word.
- R3: Status bits 0, 1 and 3 are set by any change of the bit-4, bit-5 and bit-7 level respectively. Bit 2 is set only when the bit-6 level goes from 1 to 0, which is ri_n_pin rising. A flag is set at the clock edge that follows the level change.
- R4: A cycle with status_rd at 1 clears all change flags at the next clock edge. The exception is a flag whose line changes in that same cycle; that flag stays set.
- R5: irq_req is 1 exactly when irq_enable is 1 and at least one of status bits 0 to 3 is 1.
- R6: At each clock edge where tx_idle is 1, tx_hold takes the value auto_cts_en AND NOT (status bit 4).
- R7: At a clock edge where tx_idle is 0, tx_hold keeps its value.
- R8: After reset, with all pins high and all control inputs low, status_q is 0x00 and irq_req and tx_hold are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_n_pin | input | 1 | Clear-to-send pin, active low |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low |
| ri_n_pin | input | 1 | Ring-indicator pin, active low |
| cd_n_pin | input | 1 | Carrier-detect pin, active low |
| loopback_en | input | 1 | Selects modem-control outputs as the status source |
| mctl_rts | input | 1 | Modem-control request-to-send bit |
| mctl_dtr | input | 1 | Modem-control data-terminal-ready bit |
| mctl_out1 | input | 1 | Modem-control auxiliary output 1 (control bit 2) |
| mctl_out2 | input | 1 | Modem-control auxiliary output 2 (control bit 3) |
| irq_enable | input | 1 | Modem-status interrupt enable |
| auto_cts_en | input | 1 | Enables automatic clear-to-send flow control |
| status_rd | input | 1 | Read strobe for the status word; clears flags afterwards |
| tx_idle | input | 1 | Transmitter is between characters |
| status_q | output | 8 | Status word: levels in [7:4], change flags in [3:0] |
| irq_req | output | 1 | Modem-status interrupt request |
| tx_hold | output | 1 | Holds the transmitter before its next character |

## Verification
A pin change is driven on a falling edge. It appears in the upper status bits after two rising edges, and the matching change flag follows one rising edge later. The bench checks each of these stages at the falling edge after the edge where the value is due, and it also confirms that the flag is still clear one edge earlier. In loopback the level is checked in the same cycle and the flag after one edge. The flag clear, the same-cycle re-set during a read and the tx_hold update are each due one edge after the read or idle cycle, and the bench samples them at the following falling edge.

// File: rtl/msu_pkg.sv
package msu_pkg;

  localparam int MS_LINES = 4;

  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_CD  = 3;

  typedef enum logic {
    DET_ANY_EDGE  = 1'b0,
    DET_FALL_ONLY = 1'b1
  } det_mode_e;

  function automatic det_mode_e det_mode_for(input int idx);
    return (idx == IDX_RI) ? DET_FALL_ONLY : DET_ANY_EDGE;
  endfunction

endpackage

// File: rtl/msu_rst_sync.sv
module msu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_int_n = chain_q[STAGES-1];

endmodule

// File: rtl/msu_sync_bank.sv
module msu_sync_bank #(
  parameter int         WIDTH     = 4,
  parameter int         STAGES    = 2,
  parameter logic       RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (k == 0) begin : g_first
        always_comb stage_d = din;
      end else begin : g_next
        always_comb stage_d = stage_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[k] <= {WIDTH{RESET_VAL}};
        end else begin
          stage_q[k] <= stage_d;
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/msu_delta.sv
module msu_delta
  import msu_pkg::*;
#(
  parameter int LINES = MS_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic             rd_clr,
  output logic [LINES-1:0] chg,
  output logic [LINES-1:0] flags
);

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] prev_d;
  logic [LINES-1:0] flags_d;
  logic             prev_en;

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_det
      if (det_mode_for(i) == DET_FALL_ONLY) begin : g_fall
        always_comb chg[i] = prev_q[i] & ~lvl[i];
      end else begin : g_any
        always_comb chg[i] = prev_q[i] ^ lvl[i];
      end
    end
  endgenerate

  always_comb begin
    prev_en = 1'b1;
    prev_d  = prev_en ? lvl : prev_q;
    flags_d = chg | (flags & ~{LINES{rd_clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flags  <= '0;
    end else begin
      prev_q <= prev_d;
      flags  <= flags_d;
    end
  end

endmodule

// File: rtl/msu_flow.sv
module msu_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_lvl,
  input  logic tx_idle,
  output logic hold
);

  logic hold_d;
  logic hold_en;

  always_comb begin
    hold_en = tx_idle;
    hold_d  = hold_en ? (auto_en & ~cts_lvl) : hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
    end else begin
      hold <= hold_d;
    end
  end

endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_pin,
  input  logic       dsr_n_pin,
  input  logic       ri_n_pin,
  input  logic       cd_n_pin,
  input  logic       loopback_en,
  input  logic       mctl_rts,
  input  logic       mctl_dtr,
  input  logic       mctl_out1,
  input  logic       mctl_out2,
  input  logic       irq_enable,
  input  logic       auto_cts_en,
  input  logic       status_rd,
  input  logic       tx_idle,
  output logic [7:0] status_q,
  output logic       irq_req,
  output logic       tx_hold
);

  localparam int FLAG_LSB = 0;
  localparam int LVL_LSB  = FLAG_LSB + MS_LINES;

  logic                rst_int_n;
  logic [MS_LINES-1:0] pin_raw_n;
  logic [MS_LINES-1:0] pin_sync_n;
  logic [MS_LINES-1:0] pin_lvl;
  logic [MS_LINES-1:0] loop_lvl;
  logic [MS_LINES-1:0] eff_lvl;
  logic [MS_LINES-1:0] delta_chg;
  logic [MS_LINES-1:0] delta_flags;

  msu_rst_sync #(
    .STAGES (RESET_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  always_comb begin
    pin_raw_n[IDX_CTS] = cts_n_pin;
    pin_raw_n[IDX_DSR] = dsr_n_pin;
    pin_raw_n[IDX_RI]  = ri_n_pin;
    pin_raw_n[IDX_CD]  = cd_n_pin;
    loop_lvl[IDX_CTS]  = mctl_rts;
    loop_lvl[IDX_DSR]  = mctl_dtr;
    loop_lvl[IDX_RI]   = mctl_out1;
    loop_lvl[IDX_CD]   = mctl_out2;
  end

  msu_sync_bank #(
    .WIDTH     (MS_LINES),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pin_raw_n),
    .dout  (pin_sync_n)
  );

  always_comb begin
    pin_lvl = ~pin_sync_n;
    eff_lvl = loopback_en ? loop_lvl : pin_lvl;
  end

  msu_delta #(
    .LINES (MS_LINES)
  ) u_delta (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl    (eff_lvl),
    .rd_clr (status_rd),
    .chg    (delta_chg),
    .flags  (delta_flags)
  );

  msu_flow u_flow (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .auto_en (auto_cts_en),
    .cts_lvl (eff_lvl[IDX_CTS]),
    .tx_idle (tx_idle),
    .hold    (tx_hold)
  );

  always_comb begin
    status_q                              = '0;
    status_q[LVL_LSB +: MS_LINES]         = eff_lvl;
    status_q[FLAG_LSB +: MS_LINES]        = delta_flags;
    irq_req                               = irq_enable & (|delta_flags);
  end

endmodule

// File: rtl/msu_checker.sv
module msu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       status_rd,
  input logic [7:0] status_q,
  input logic [3:0] chg,
  input logic       irq_enable,
  input logic       irq_req,
  input logic       tx_idle,
  input logic       tx_hold,
  input logic       auto_cts_en
);

  // R4: after a read only lines that changed during the read cycle remain flagged
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> ((status_q[3:0] & ~$past(chg)) == 4'b0));

  // R5: no request while disabled
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !irq_req);

  // R7: hold frozen while a character is in flight
  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(tx_hold));

  // R6: flow control off releases the hold at the next idle edge
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !auto_cts_en) |=> !tx_hold);

  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_flag
      // R3: a flag only rises after a detected change on its line
      a_r3_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[i]) |-> $past(chg[i]));
    end
  endgenerate

endmodule

bind modem_status_unit msu_checker u_msu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_rd   (status_rd),
  .status_q    (status_q),
  .chg         (delta_chg),
  .irq_enable  (irq_enable),
  .irq_req     (irq_req),
  .tx_idle     (tx_idle),
  .tx_hold     (tx_hold),
  .auto_cts_en (auto_cts_en)
);

// File: tb/modem_status_unit_tb.sv
module modem_status_unit_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic       clk;
  logic       rst_n;
  logic       cts_n_pin, dsr_n_pin, ri_n_pin, cd_n_pin;
  logic       loopback_en;
  logic       mctl_rts, mctl_dtr, mctl_out1, mctl_out2;
  logic       irq_enable, auto_cts_en, status_rd, tx_idle;
  logic [7:0] status_q;
  logic       irq_req, tx_hold;

  int n_checks;
  int n_fail;
  bit done;

  modem_status_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n_pin   (cts_n_pin),
    .dsr_n_pin   (dsr_n_pin),
    .ri_n_pin    (ri_n_pin),
    .cd_n_pin    (cd_n_pin),
    .loopback_en (loopback_en),
    .mctl_rts    (mctl_rts),
    .mctl_dtr    (mctl_dtr),
    .mctl_out1   (mctl_out1),
    .mctl_out2   (mctl_out2),
    .irq_enable  (irq_enable),
    .auto_cts_en (auto_cts_en),
    .status_rd   (status_rd),
    .tx_idle     (tx_idle),
    .status_q    (status_q),
    .irq_req     (irq_req),
    .tx_hold     (tx_hold)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(output logic [7:0] v);
    status_rd = 1'b1;
    #1 v = status_q;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0;
    cts_n_pin = 1; dsr_n_pin = 1; ri_n_pin = 1; cd_n_pin = 1;
    loopback_en = 0; mctl_rts = 0; mctl_dtr = 0; mctl_out1 = 0; mctl_out2 = 0;
    irq_enable = 0; auto_cts_en = 0; status_rd = 0; tx_idle = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges(4);
    chk("R8 status after reset", status_q, 8'h00);
    chk("R8 irq/hold after reset", {6'b0, irq_req, tx_hold}, 8'h00);
    do_read(v);
  endtask

  task automatic t_pins();
    logic [7:0] v;
    cts_n_pin = 0;
    edges(1);
    chk("R1 not yet visible after one edge", status_q, 8'h00);
    edges(1);
    chk("R1 cts level after two edges", status_q, 8'h10);
    edges(1);
    chk("R3 cts flag one edge later", status_q, 8'h11);
    do_read(v);
    chk("R4 read returns flag", v, 8'h11);
    chk("R4 flag cleared after read", status_q, 8'h10);
    dsr_n_pin = 0; cd_n_pin = 0;
    edges(3);
    chk("R1 R3 dsr and cd", status_q, 8'hBA);
    do_read(v);
    ri_n_pin = 0;
    edges(3);
    chk("R3 ri going active sets no flag", status_q, 8'hF0);
    ri_n_pin = 1;
    edges(2);
    chk("R1 ri inactive level", status_q, 8'hB0);
    edges(1);
    chk("R3 ri trailing edge flag", status_q, 8'hB4);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    irq_enable = 0;
    #1 chk("R5 irq masked", {7'b0, irq_req}, 8'h00);
    irq_enable = 1;
    #1 chk("R5 irq with flag and enable", {7'b0, irq_req}, 8'h01);
    do_read(v);
    chk("R5 irq drops after clear", {7'b0, irq_req}, 8'h00);
    irq_enable = 0;
  endtask

  task automatic t_loopback();
    logic [7:0] v;
    cts_n_pin = 1; dsr_n_pin = 1; ri_n_pin = 1; cd_n_pin = 1;
    edges(4);
    do_read(v);
    mctl_rts = 1; mctl_dtr = 0; mctl_out1 = 1; mctl_out2 = 0;
    loopback_en = 1;
    #1 chk("R2 loopback map same cycle", {status_q[7:4], 4'h0}, 8'h50);
    @(negedge clk);
    do_read(v);
    cts_n_pin = 0; dsr_n_pin = 0; ri_n_pin = 0; cd_n_pin = 0;
    edges(4);
    chk("R2 pins ignored in loopback", status_q, 8'h50);
    mctl_out2 = 1;
    #1 chk("R2 control bit 3 to bit 7", status_q, 8'hD0);
    edges(1);
    chk("R3 cd flag via loopback", status_q, 8'hD8);
    status_rd = 1'b1;
    mctl_rts = 0;
    @(negedge clk);
    status_rd = 1'b0;
    chk("R4 change during read keeps flag", status_q, 8'hC1);
    do_read(v);
    chk("R4 later read clears", status_q, 8'hC0);
    loopback_en = 0;
    edges(4);
    do_read(v);
  endtask

  task automatic t_flow();
    auto_cts_en = 1; tx_idle = 1; cts_n_pin = 1;
    edges(3);
    chk("R6 hold when cts inactive", {7'b0, tx_hold}, 8'h01);
    tx_idle = 0; cts_n_pin = 0;
    edges(5);
    chk("R7 hold kept during character", {7'b0, tx_hold}, 8'h01);
    tx_idle = 1;
    edges(1);
    chk("R6 hold released at idle", {7'b0, tx_hold}, 8'h00);
    tx_idle = 0; cts_n_pin = 1;
    edges(4);
    chk("R7 no hold mid character", {7'b0, tx_hold}, 8'h00);
    tx_idle = 1;
    edges(1);
    chk("R6 hold set at idle", {7'b0, tx_hold}, 8'h01);
    auto_cts_en = 0;
    edges(1);
    chk("R6 hold off when disabled", {7'b0, tx_hold}, 8'h00);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 0;
    t_reset();
    t_pins();
    t_irq();
    t_loopback();
    t_flow();
    done = 1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule